// File: doc/BRIEF.md
# USB Host Interrupt Controller

This block gathers the interrupt causes of a small two-channel USB host controller and turns them into a single level-type request line for the host CPU. Single-cycle event strobes come from the outside. They are the transfer-complete strobes of channel A and channel B, the frame-start tick, the attach/detach change and the device-detect and resume events. Each strobe latches a sticky bit in a status register. A separate enable register decides which of those latched bits may drive the request line.

Software reaches both registers through a byte-wide register port with combinational read data. It clears a status bit by writing a 1 to that bit position. Two control bits held elsewhere in the controller are wired in as inputs. One selects whether the shared detect bit follows resume events or device-detect events. The other says whether the frame-start generator is running. Frame ticks are ignored while it is stopped.

Top module: `usb_host_irq_ctrl`

## Requirements
- R1: The enable register sits at byte address 06h. Bit 0 enables channel-A done, bit 1 channel-B done, bit 4 frame-start, bit 5 attach/detach and bit 6 detect/resume. Bits 7, 3 and 2 ignore writes and read back as 0.
- R2: The status register sits at byte address 0Dh and uses the same bit positions as the enable register. A one-cycle strobe on `done_a`, `done_b` or `attach_chg` sets bit 0, bit 1 or bit 5 respectively, and the new value is readable from the next cycle on. Bits 7, 3 and 2 read as 0.
- R3: Writing 0Dh clears every status bit whose write-data bit is 1 and leaves the bits written 0 unchanged. When a clear and a new event hit the same bit in the same cycle, the bit ends up set.
- R4: Whether a status bit gets set or cleared does not depend on the enable register.
- R5: `irq` is high exactly when some status bit and its enable bit were both 1 in the previous cycle. It therefore follows a status or enable change with one clock of delay and stays high until every enabled set bit has been cleared.
- R6: When `resume_sel` is 1, `resume_evt` sets status bit 6 and `detect_evt` is ignored. When `resume_sel` is 0, `detect_evt` sets bit 6 and `resume_evt` is ignored.
- R7: `frame_tick` sets status bit 4 only while `frame_en` is 1. With `frame_en` at 0 it leaves the bit unchanged.
- R8: Asserting `rst_n` low clears the enable register, the status register and `irq`.
- R9: `rdata` is 0 when `rd_en` is low, and also when the address is neither 06h nor 0Dh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Combinational read data |
| frame_en | input | 1 | Frame-start generator running |
| resume_sel | input | 1 | Bit 6 source: 1 resume, 0 device detect |
| done_a | input | 1 | Channel-A transfer complete strobe |
| done_b | input | 1 | Channel-B transfer complete strobe |
| frame_tick | input | 1 | Frame-start timer strobe |
| attach_chg | input | 1 | Device attach/detach strobe |
| detect_evt | input | 1 | Device-detect strobe |
| resume_evt | input | 1 | Resume-detect strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a clear and a new event landing on the same status bit in the same cycle. The bench reaches it by issuing the 0Dh write in the cycle that also pulses each strobe. It repeats this for both values of `resume_sel`, so that the active bit-6 source and the ignored bit-6 source are both tried against the clear. The registered request line is checked in the cycle right after each enable write and after each clear. Those checks are made across all 128 enable patterns with every status bit set, so the one-cycle delay is confirmed for each mask and not just the final level.

// File: rtl/usb_host_irq_ctrl.sv
module usb_host_irq_ctrl #(
  parameter logic [7:0] EN_ADDR   = 8'h06,
  parameter logic [7:0] STAT_ADDR = 8'h0D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic       frame_en,
  input  logic       resume_sel,
  input  logic       done_a,
  input  logic       done_b,
  input  logic       frame_tick,
  input  logic       attach_chg,
  input  logic       detect_evt,
  input  logic       resume_evt,
  output logic       irq
);
  localparam logic [7:0] LIVE = 8'h73;

  logic [7:0] en_q, stat_q, set_v, clr_v;
  logic       irq_q;

  assign set_v = {1'b0,
                  resume_sel ? resume_evt : detect_evt,
                  attach_chg,
                  frame_tick & frame_en,
                  2'b00,
                  done_b,
                  done_a};

  assign clr_v = (wr_en && addr == STAT_ADDR) ? (wdata & LIVE) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 8'h00;
      stat_q <= 8'h00;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en && addr == EN_ADDR) en_q <= wdata & LIVE;
      stat_q <= (stat_q & ~clr_v) | set_v;
      irq_q  <= |(stat_q & en_q);
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (addr == EN_ADDR)        rdata = en_q;
      else if (addr == STAT_ADDR) rdata = stat_q;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/usb_host_irq_ctrl_chk.sv
module usb_host_irq_ctrl_chk #(
  parameter logic [7:0] STAT_ADDR = 8'h0D
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       wr_en,
  input logic       frame_en,
  input logic       done_a,
  input logic       done_b,
  input logic [7:0] en_q,
  input logic [7:0] stat_q,
  input logic       irq
);
  // R5
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(stat_q & en_q)));

  // R1
  en_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & 8'h8C) == 8'h00);

  // R2
  done_a_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_a |=> stat_q[0]);

  // R7
  frame_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_en && !stat_q[4]) |=> !stat_q[4]);

  // R3
  clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == STAT_ADDR && wdata[1] && !done_b) |=> !stat_q[1]);
endmodule

bind usb_host_irq_ctrl usb_host_irq_ctrl_chk #(.STAT_ADDR(STAT_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .frame_en(frame_en), .done_a(done_a), .done_b(done_b),
  .en_q(en_q), .stat_q(stat_q), .irq(irq));

// File: tb/tb_usb_host_irq_ctrl.sv
module tb_usb_host_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic       frame_en = 1'b0, resume_sel = 1'b0;
  logic [5:0] ev = 6'b0;
  logic       irq;

  usb_host_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .frame_en(frame_en), .resume_sel(resume_sel),
    .done_a(ev[0]), .done_b(ev[1]), .frame_tick(ev[2]), .attach_chg(ev[3]),
    .detect_evt(ev[4]), .resume_evt(ev[5]), .irq(irq));

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic [7:0] m_en = 0, m_stat = 0;
  logic       m_irq = 0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(input logic [7:0] a);
    return 8'h0;
  endfunction

  task automatic rdreg(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1; #1; d = rdata; rd_en = 1'b0; addr = 8'h00;
  endtask

  // one clock: inputs applied at negedge, model updated from the requirements
  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic [5:0] e);
    logic [7:0] set, clr;
    wr_en = w; addr = a; wdata = d; ev = e;
    @(posedge clk);
    set = 8'h0;
    set[0] = e[0]; set[1] = e[1]; set[4] = e[2] & frame_en; set[5] = e[3];
    set[6] = resume_sel ? e[5] : e[4];
    clr = (w && a == 8'h0D) ? (d & 8'h73) : 8'h00;
    m_irq = |(m_stat & m_en);
    if (w && a == 8'h06) m_en = d & 8'h73;
    m_stat = (m_stat & ~clr) | set;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00; wdata = 8'h00; ev = 6'b0;
  endtask

  task automatic check_state(input string tag);
    logic [7:0] d;
    rdreg(8'h0D, d); chk(d, m_stat, {tag, " status"});
    rdreg(8'h06, d); chk(d, m_en, {tag, " enable"});
    chk({7'b0, irq}, {7'b0, m_irq}, {tag, " irq"});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; #2; rst_n = 1'b1;
    m_en = 0; m_stat = 0; m_irq = 0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_state("R8 reset");

    // R1: enable readback sweep, reserved bits masked
    for (int w = 0; w < 256; w++) begin
      step(1, 8'h06, w[7:0], 6'b0);
      rdreg(8'h06, d); chk(d, w[7:0] & 8'h73, "R1 enable readback");
    end
    step(1, 8'h06, 8'h00, 6'b0); step(0, 0, 0, 6'b0);

    // R2 R4 R6 R7: each source under each control setting, enables off
    for (int fe = 0; fe < 2; fe++)
      for (int rs = 0; rs < 2; rs++)
        for (int s = 0; s < 6; s++) begin
          frame_en = fe[0]; resume_sel = rs[0];
          step(0, 0, 0, 6'b1 << s);
          check_state((s == 2) ? "R7 frame gate" : (s >= 4) ? "R6 detect select" : "R2 event set");
          chk({7'b0, irq}, 8'h00, "R4 enable off keeps irq low");
          step(0, 0, 0, 6'b0);
          check_state("R4 status set with enable off");
          step(1, 8'h0D, 8'hFF, 6'b0);
          check_state("R3 clear all");
        end

    // R5: all status set, sweep every enable pattern
    frame_en = 1'b1; resume_sel = 1'b1;
    step(0, 0, 0, 6'b101111);
    for (int w = 0; w < 128; w++) begin
      step(1, 8'h06, w[7:0], 6'b0);
      check_state("R5 irq lags enable write");
      step(0, 0, 0, 6'b0);
      check_state("R5 irq follows enable");
    end

    // R5 R3: clear bits one by one with all enabled; irq stays until last
    step(1, 8'h06, 8'h73, 6'b0); step(0, 0, 0, 6'b0);
    for (int b = 0; b < 8; b++) begin
      step(1, 8'h0D, 8'h01 << b, 6'b0);
      check_state("R3 single clear");
      step(0, 0, 0, 6'b0);
      check_state("R5 level until all cleared");
    end

    // R3: write of 0 leaves status; set wins over clear
    step(0, 0, 0, 6'b001011);
    step(1, 8'h0D, 8'h00, 6'b0);
    check_state("R3 zero write no effect");
    step(1, 8'h0D, 8'hFF, 6'b0); step(0, 0, 0, 6'b0);
    for (int rs = 0; rs < 2; rs++)
      for (int s = 0; s < 6; s++) begin
        resume_sel = rs[0];
        step(1, 8'h0D, 8'hFF, 6'b1 << s);
        check_state((s >= 4) ? "R6 R3 set wins with select" : "R3 set wins");
        step(1, 8'h0D, 8'hFF, 6'b0);
      end

    // R9: other addresses and idle read strobe
    step(0, 0, 0, 6'b001011);
    for (int a = 0; a < 256; a++) begin
      addr = a[7:0]; rd_en = 1'b0; #1;
      chk(rdata, 8'h00, "R9 rd_en low");
      if (a != 8'h06 && a != 8'h0D) begin
        rd_en = 1'b1; #1;
        chk(rdata, 8'h00, "R9 unmapped read");
      end
      rd_en = 1'b0;
    end
    addr = 8'h00;

    // R8: reset mid-operation
    step(0, 0, 0, 6'b0);
    chk({7'b0, irq}, 8'h01, "R8 irq high before reset");
    do_reset();
    check_state("R8 reset mid-run");

    finish_run();
  end
endmodule